// File: doc/BRIEF.md
# Sticky Event Status and Service-Request Logic

This block keeps an 8-bit event status byte for an instrument controller. Each status bit is set by a one-cycle strobe, or by the rising edge of a level in the case of the settled bit. A set bit stays set until software clears the byte. A writable enable mask picks the events that may request service. When an enabled status bit goes from 0 to 1, the block sets the service-request bit (bit 6) and raises an interrupt line that follows that bit.

The byte holds zero until a power-up completion strobe arrives. That strobe leaves only the settled bit set. The byte can then be cleared in three ways: by a clear-status strobe, by a device-clear strobe, or by a status query. The query clears the byte only when the service-request bit is set. A serial poll reads the byte without changing it. The poll is the only read honoured before power-up completes. Reads are latched onto the read-data port one cycle after the read strobe.

Top module: `statusSrqUnit`

## Requirements
- R1: Before the first power-up completion strobe, the status byte stays 0 and every event strobe is ignored. A serial poll in that phase returns 0, and the interrupt line stays low.
- R2: A power-up completion strobe leaves the status byte at exactly 8'h04, with only bit 2 (settled) set. Events in that same cycle are ignored.
- R3: Each event strobe sets its own bit, and the bit stays set after the strobe ends. The bits are: self-test error bit 7, syntax error bit 5, message available bit 4, parameter error bit 0.
- R4: Bit 2 (settled) is set only on a 0-to-1 change of the settled level input. A level that stays high does not set the bit again after a clear.
- R5: A clear-status strobe or a device-clear strobe clears the whole status byte to 0.
- R6: A status query latches the byte onto the read-data port one cycle later. The query clears the byte only if bit 6 was 1 at the time of the query. Otherwise the byte is unchanged.
- R7: A serial poll latches the byte onto the read-data port one cycle later and leaves the byte unchanged.
- R8: When a status bit whose mask bit is 1 goes from 0 to 1, bit 6 is set and the interrupt line goes high in the same cycle. The maskable bits are 7, 5, 4, 2 and 0. Mask bits 6, 3 and 1 have no effect.
- R9: No service request is raised in three cases: the bit is unmasked, the bit was already set, or the bit becomes enabled by a mask write while it is already set.
- R10: When a set event and a clear arrive in the same cycle, the event's bit ends up set. If that bit is enabled, the service request is also raised.
- R11: Status bits 3 and 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pwrUpDone | input | 1 | Power-up completion strobe |
| evSelfTest | input | 1 | Self-test (calibration) error strobe |
| evSyntax | input | 1 | Syntax error strobe |
| evParam | input | 1 | Parameter out-of-range strobe |
| evMsgAvail | input | 1 | Message-available strobe |
| settledLvl | input | 1 | Settled condition level |
| clrStatus | input | 1 | Clear-status strobe |
| devClear | input | 1 | Device-clear strobe |
| queryRd | input | 1 | Status query read strobe |
| pollRd | input | 1 | Serial poll read strobe |
| maskWr | input | 1 | Mask write strobe |
| maskData | input | 8 | Mask write data |
| rdData | output | 8 | Latched status byte from the last honoured read |
| srqIrq | output | 1 | Service-request interrupt level |

## Verification
A lost or spurious sticky bit shows up on the next poll, one cycle after the poll strobe. A wrong 0-to-1 decision, such as firing on a level or ignoring the mask, shows on the interrupt line right after the edge that sets the bit. A wrong power-up flag or wrong settled-edge history shows as an extra or missing bit 2, or as events that are not ignored. A query that clears when bit 6 is low shows on the poll that follows it.

// File: rtl/statusPkg.sv
package statusPkg;
  localparam int STW = 8;
  localparam int SELFTEST_BIT = 7;
  localparam int SRQ_BIT = 6;
  localparam int SYNTAX_BIT = 5;
  localparam int MSG_BIT = 4;
  localparam int SETTLED_BIT = 2;
  localparam int PARAM_BIT = 0;
  localparam logic [STW-1:0] IRQ_ABLE_MASK =
    STW'((1 << SELFTEST_BIT) | (1 << SYNTAX_BIT) | (1 << MSG_BIT) |
         (1 << SETTLED_BIT) | (1 << PARAM_BIT));

  typedef struct packed {
    logic           clearAll;
    logic           rdLatch;
    logic [STW-1:0] setVec;
  } statusCtrlT;
endpackage

// File: rtl/statusCtrl.sv
module statusCtrl
  import statusPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrUpDone,
  input  logic       evSelfTest,
  input  logic       evSyntax,
  input  logic       evParam,
  input  logic       evMsgAvail,
  input  logic       settledLvl,
  input  logic       clrStatus,
  input  logic       devClear,
  input  logic       queryRd,
  input  logic       pollRd,
  input  logic       srqBit,
  output statusCtrlT ctrl,
  output logic       powered
);
  logic poweredQ;
  logic settledPrev;
  logic settledRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      poweredQ    <= 1'b0;
      settledPrev <= 1'b0;
    end else begin
      poweredQ    <= poweredQ | pwrUpDone;
      settledPrev <= settledLvl;
    end
  end

  assign settledRise = settledLvl & ~settledPrev;
  assign powered = poweredQ;

  always_comb begin
    ctrl = '0;
    if (!poweredQ) begin
      if (pwrUpDone) begin
        ctrl.clearAll = 1'b1;
        ctrl.setVec[SETTLED_BIT] = 1'b1;
      end
    end else begin
      ctrl.setVec[SELFTEST_BIT] = evSelfTest;
      ctrl.setVec[SYNTAX_BIT]   = evSyntax;
      ctrl.setVec[MSG_BIT]      = evMsgAvail;
      ctrl.setVec[SETTLED_BIT]  = settledRise;
      ctrl.setVec[PARAM_BIT]    = evParam;
      ctrl.clearAll = clrStatus | devClear | (queryRd & srqBit);
    end
    ctrl.rdLatch = pollRd | (queryRd & poweredQ);
  end
endmodule

// File: rtl/statusDatapath.sv
module statusDatapath
  import statusPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  statusCtrlT     ctrl,
  input  logic           maskWr,
  input  logic [STW-1:0] maskData,
  output logic [STW-1:0] statusQ,
  output logic [STW-1:0] maskQ,
  output logic [STW-1:0] rdData
);
  logic [STW-1:0] statusD;
  logic [STW-1:0] riseVec;
  logic           anyRise;

  assign riseVec = ctrl.setVec & ~statusQ & maskQ;
  assign anyRise = |riseVec;

  for (genvar i = 0; i < STW; i++) begin : gBit
    if (i == SRQ_BIT) begin : gSrq
      assign statusD[i] = (statusQ[i] & ~ctrl.clearAll) | anyRise;
    end else if (IRQ_ABLE_MASK[i]) begin : gEvt
      assign statusD[i] = (statusQ[i] & ~ctrl.clearAll) | ctrl.setVec[i];
    end else begin : gRsv
      assign statusD[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= '0;
      rdData  <= '0;
    end else begin
      statusQ <= statusD;
      if (maskWr) maskQ <= maskData & IRQ_ABLE_MASK;
      if (ctrl.rdLatch) rdData <= statusQ;
    end
  end
endmodule

// File: rtl/statusSrqUnit.sv
module statusSrqUnit
  import statusPkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           pwrUpDone,
  input  logic           evSelfTest,
  input  logic           evSyntax,
  input  logic           evParam,
  input  logic           evMsgAvail,
  input  logic           settledLvl,
  input  logic           clrStatus,
  input  logic           devClear,
  input  logic           queryRd,
  input  logic           pollRd,
  input  logic           maskWr,
  input  logic [STW-1:0] maskData,
  output logic [STW-1:0] rdData,
  output logic           srqIrq
);
  statusCtrlT     ctrl;
  logic           powered;
  logic [STW-1:0] statusQ;
  logic [STW-1:0] maskQ;

  statusCtrl uCtrl (
    .clk(clk), .rstN(rstN), .pwrUpDone(pwrUpDone),
    .evSelfTest(evSelfTest), .evSyntax(evSyntax), .evParam(evParam),
    .evMsgAvail(evMsgAvail), .settledLvl(settledLvl),
    .clrStatus(clrStatus), .devClear(devClear), .queryRd(queryRd),
    .pollRd(pollRd), .srqBit(statusQ[SRQ_BIT]), .ctrl(ctrl),
    .powered(powered)
  );

  statusDatapath uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .maskWr(maskWr),
    .maskData(maskData), .statusQ(statusQ), .maskQ(maskQ),
    .rdData(rdData)
  );

  assign srqIrq = statusQ[SRQ_BIT];
endmodule

// File: rtl/statusSrqChk.sv
module statusSrqChk
  import statusPkg::*;
(
  input logic           clk,
  input logic           rstN,
  input logic           evSyntax,
  input logic           evSelfTest,
  input logic           evParam,
  input logic           evMsgAvail,
  input logic           pwrUpDone,
  input logic           settledLvl,
  input logic           clrStatus,
  input logic           devClear,
  input logic           queryRd,
  input logic           powered,
  input logic [STW-1:0] statusQ,
  input logic [STW-1:0] maskQ,
  input logic           srqIrq
);
  logic quiet;
  assign quiet = !evSyntax && !evSelfTest && !evParam && !evMsgAvail &&
                 !pwrUpDone && !settledLvl;

  a_r11_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    statusQ[3] == 1'b0 && statusQ[1] == 1'b0);

  a_r1_zero_before_power: assert property (@(posedge clk) disable iff (!rstN)
    !powered |-> (statusQ == '0 && !srqIrq));

  a_r3_syntax_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ[SYNTAX_BIT] && !clrStatus && !devClear && !queryRd)
      |=> statusQ[SYNTAX_BIT]);

  a_r5_clear_all: assert property (@(posedge clk) disable iff (!rstN)
    (powered && (clrStatus || devClear) && quiet) |=> statusQ == '0);

  a_r6_query_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (powered && queryRd && !statusQ[SRQ_BIT] && !clrStatus && !devClear && quiet)
      |=> $stable(statusQ));

  a_r8_syntax_raises_srq: assert property (@(posedge clk) disable iff (!rstN)
    (powered && evSyntax && maskQ[SYNTAX_BIT] && !statusQ[SYNTAX_BIT])
      |=> (statusQ[SRQ_BIT] && srqIrq));
endmodule

bind statusSrqUnit statusSrqChk chk (
  .clk(clk), .rstN(rstN), .evSyntax(evSyntax), .evSelfTest(evSelfTest),
  .evParam(evParam), .evMsgAvail(evMsgAvail), .pwrUpDone(pwrUpDone),
  .settledLvl(settledLvl), .clrStatus(clrStatus), .devClear(devClear),
  .queryRd(queryRd), .powered(powered), .statusQ(statusQ), .maskQ(maskQ),
  .srqIrq(srqIrq)
);

// File: tb/tb_statusSrqUnit.sv
module tb_statusSrqUnit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrUpDone = 0, evSelfTest = 0, evSyntax = 0, evParam = 0, evMsgAvail = 0;
  logic settledLvl = 0, clrStatus = 0, devClear = 0, queryRd = 0, pollRd = 0;
  logic maskWr = 0;
  logic [7:0] maskData = '0;
  logic [7:0] rdData;
  logic srqIrq;
  int totalCnt = 0;
  int failCnt = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  statusSrqUnit dut (
    .clk(clk), .rstN(rstN), .pwrUpDone(pwrUpDone), .evSelfTest(evSelfTest),
    .evSyntax(evSyntax), .evParam(evParam), .evMsgAvail(evMsgAvail),
    .settledLvl(settledLvl), .clrStatus(clrStatus), .devClear(devClear),
    .queryRd(queryRd), .pollRd(pollRd), .maskWr(maskWr), .maskData(maskData),
    .rdData(rdData), .srqIrq(srqIrq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      failCnt++; totalCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic poll(output logic [7:0] v);
    pollRd = 1; @(negedge clk); pollRd = 0; v = rdData;
  endtask

  task automatic wrMask(logic [7:0] m);
    maskWr = 1; maskData = m; @(negedge clk); maskWr = 0;
  endtask

  task automatic doClr();
    clrStatus = 1; @(negedge clk); clrStatus = 0;
  endtask

  task automatic tReset();
    logic [7:0] v;
    check("R1 srq after reset", {7'b0, srqIrq}, 8'h00);
    poll(v); check("R1 poll after reset", v, 8'h00);
    evSyntax = 1; evParam = 1; @(negedge clk); evSyntax = 0; evParam = 0;
    poll(v); check("R1 events ignored before power", v, 8'h00);
    check("R1 srq before power", {7'b0, srqIrq}, 8'h00);
  endtask

  task automatic tPower();
    logic [7:0] v;
    pwrUpDone = 1; evSyntax = 1; @(negedge clk); pwrUpDone = 0; evSyntax = 0;
    poll(v); check("R2 power-up byte", v, 8'h04);
  endtask

  task automatic tSticky();
    logic [7:0] v;
    evSyntax = 1; @(negedge clk); evSyntax = 0;
    idle();
    poll(v); check("R3 syntax sticky", v, 8'h24);
    poll(v); check("R7 poll leaves byte", v, 8'h24);
    evParam = 1; evMsgAvail = 1; evSelfTest = 1; @(negedge clk);
    evParam = 0; evMsgAvail = 0; evSelfTest = 0;
    poll(v); check("R3 R11 all events", v, 8'hB5);
    check("R9 no srq unmasked", {7'b0, srqIrq}, 8'h00);
  endtask

  task automatic tClear();
    logic [7:0] v;
    doClr(); poll(v); check("R5 clear-status", v, 8'h00);
    evSyntax = 1; @(negedge clk); evSyntax = 0;
    devClear = 1; @(negedge clk); devClear = 0;
    poll(v); check("R5 device-clear", v, 8'h00);
  endtask

  task automatic tSettled();
    logic [7:0] v;
    settledLvl = 1; @(negedge clk);
    poll(v); check("R4 settled rise", v, 8'h04);
    doClr(); idle();
    poll(v); check("R4 steady level no reset", v, 8'h00);
    settledLvl = 0; @(negedge clk); settledLvl = 1; @(negedge clk);
    poll(v); check("R4 second rise", v, 8'h04);
    settledLvl = 0; @(negedge clk);
  endtask

  task automatic tQueryKeep();
    logic [7:0] v;
    doClr();
    evSyntax = 1; @(negedge clk); evSyntax = 0;
    queryRd = 1; @(negedge clk); queryRd = 0;
    check("R6 query returns byte", rdData, 8'h20);
    poll(v); check("R6 query without srq keeps", v, 8'h20);
  endtask

  task automatic tSrq();
    logic [7:0] v;
    doClr(); wrMask(8'h20);
    evSyntax = 1; @(negedge clk); evSyntax = 0;
    check("R8 srq line raised", {7'b0, srqIrq}, 8'h01);
    poll(v); check("R8 bit6 set", v, 8'h60);
    queryRd = 1; @(negedge clk); queryRd = 0;
    check("R6 query returns srq byte", rdData, 8'h60);
    poll(v); check("R6 query with srq clears", v, 8'h00);
    check("R6 srq falls after clear", {7'b0, srqIrq}, 8'h00);
  endtask

  task automatic tNoSrq();
    logic [7:0] v;
    doClr(); wrMask(8'h00);
    evParam = 1; @(negedge clk); evParam = 0;
    wrMask(8'h01);
    check("R9 mask on set bit no srq", {7'b0, srqIrq}, 8'h00);
    evParam = 1; @(negedge clk); evParam = 0;
    poll(v); check("R9 repeat event no srq", v, 8'h01);
    doClr(); wrMask(8'h4A);
    evSyntax = 1; evSelfTest = 1; evParam = 1; evMsgAvail = 1; @(negedge clk);
    evSyntax = 0; evSelfTest = 0; evParam = 0; evMsgAvail = 0;
    poll(v); check("R8 R11 mask bits 6,3,1 inert", v, 8'hB1);
  endtask

  task automatic tSetWins();
    logic [7:0] v;
    doClr(); wrMask(8'h00);
    evParam = 1; @(negedge clk); evParam = 0;
    clrStatus = 1; evMsgAvail = 1; @(negedge clk); clrStatus = 0; evMsgAvail = 0;
    poll(v); check("R10 set beats clear", v, 8'h10);
    doClr(); wrMask(8'h10);
    devClear = 1; evMsgAvail = 1; @(negedge clk); devClear = 0; evMsgAvail = 0;
    check("R10 srq on set during clear", {7'b0, srqIrq}, 8'h01);
    poll(v); check("R10 byte with srq", v, 8'h50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tPower();
    tSticky();
    tClear();
    tSettled();
    tQueryKeep();
    tSrq();
    tNoSrq();
    tSetWins();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule